// File: doc/BRIEF.md
# Dual-Channel Fine Gain Trim

This block raises the gain of two streams of signed converter samples by a small, programmable amount. Each sample is multiplied by one plus a 7-bit trim code divided by 8192, so the code can only raise the gain, by about 0.134 dB at most. The correction term, sample times code over 8192, is rounded to an integer and added to the sample. The sum is clamped to the signed sample range.

Both channels share one valid strobe. A mode input selects whether each channel uses its own trim code, or whether the first channel's code drives both channels. The datapath has two register stages. The trim code and the mode are captured at the same clock edge as the sample they scale, so a code change never alters a sample that is already in flight.

Top module: `fgt_dual_trim`

## Requirements
- R1: While rst_n is low, and until the first accepted sample has left the pipeline after reset is released, out_valid is 0 and out_a and out_b are 0, even if in_valid is high during reset.
- R2: A sample accepted with in_valid high at rising edge N appears with out_valid high after edge N+1. out_valid is high for exactly one cycle per accepted sample, and it is low in cycles that correspond to in_valid low.
- R3: For a sample x and a code c (unsigned 0 to 127), the output is x + round(x*c/8192), where the code is interpreted as a plain unsigned integer.
- R4: The correction term rounds halves away from zero. For example, x=4096 with c=1 gives 4097, x=-4096 with c=1 gives -4097, and x=-4095 with c=1 gives -4095.
- R5: A result above 2^(DW-1)-1 is clamped to 2^(DW-1)-1, and a result below -2^(DW-1) is clamped to -2^(DW-1). The result never wraps.
- R6: Code 0 passes every sample through unchanged.
- R7: With common_sel=1, code_a scales both channels and code_b has no effect on out_b.
- R8: With common_sel=0, out_a uses code_a and out_b uses code_b.
- R9: The code and the mode are sampled at the same edge as the sample. A change applied in the cycle after a sample is accepted does not affect that sample.
- R10: In cycles where out_valid is low, out_a and out_b hold the last valid result.
- R11: A non-negative input never produces a smaller output, and a negative input never produces a larger output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Sample strobe for both channels |
| in_a | input | DW | Signed sample, first channel |
| in_b | input | DW | Signed sample, second channel |
| code_a | input | CW | Trim code, first channel (also drives both channels in common mode) |
| code_b | input | CW | Trim code, second channel |
| common_sel | input | 1 | 1 = code_a drives both channels, 0 = each channel uses its own code |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_a | output | DW | Trimmed, rounded, saturated result, first channel |
| out_b | output | DW | Trimmed, rounded, saturated result, second channel |

## Verification
The hardest cases to reach are products that land exactly halfway between two integers after the 13-bit shift, and full-scale samples that are pushed past the range limits. Random data rarely hits either case. Directed operand pairs cover both: their products are odd multiples of 4096, or they are extreme samples combined with code 127. Coverage of R9 depends on the code and the mode changing on every cycle while samples flow back to back. A behavioural queue model records the code and the mode together with each sample, so any capture at the wrong edge shows up as a data mismatch two cycles later.

// File: rtl/fgt_pkg.sv
`timescale 1ns/1ps
package fgt_pkg;
  typedef enum logic {
    MODE_INDEP  = 1'b0,
    MODE_COMMON = 1'b1
  } trim_mode_e;

  localparam int FGT_FRAC_BITS = 13;
endpackage

// File: rtl/fgt_code_sel.sv
`timescale 1ns/1ps
module fgt_code_sel #(
  parameter int NCH = 2,
  parameter int CW  = 7
) (
  input  logic              mode_common_i,
  input  logic [NCH*CW-1:0] codes_i,
  output logic [NCH*CW-1:0] codes_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_lane
    if (g == 0) begin : g_ref
      assign codes_o[CW-1:0] = codes_i[CW-1:0];
    end else begin : g_dep
      assign codes_o[g*CW +: CW] = mode_common_i ? codes_i[CW-1:0]
                                                 : codes_i[g*CW +: CW];
    end
  end
endmodule

// File: rtl/fgt_product_stage.sv
`timescale 1ns/1ps
module fgt_product_stage #(
  parameter int DW = 14,
  parameter int CW = 7,
  parameter int PW = DW + CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic        [CW-1:0] code_i,
  output logic signed [DW-1:0] sample_o,
  output logic signed [PW-1:0] prod_o
);
  logic signed [PW-1:0] samp_x;
  logic signed [PW-1:0] code_x;
  logic signed [PW-1:0] prod_d;
  logic signed [DW-1:0] sample_d;

  always_comb begin
    samp_x   = {{(PW-DW){sample_i[DW-1]}}, sample_i};
    code_x   = {{(PW-CW){1'b0}}, code_i};
    sample_d = sample_o;
    prod_d   = prod_o;
    if (en_i) begin
      sample_d = sample_i;
      prod_d   = samp_x * code_x;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_o <= '0;
      prod_o   <= '0;
    end else begin
      sample_o <= sample_d;
      prod_o   <= prod_d;
    end
  end

  // R6: a zero code contributes no correction term
  p_zero_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && code_i == '0) |=> (prod_o == '0));
endmodule

// File: rtl/fgt_round_sat_stage.sv
`timescale 1ns/1ps
module fgt_round_sat_stage #(
  parameter int DW   = 14,
  parameter int PW   = 22,
  parameter int FRAC = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic signed [PW-1:0] prod_i,
  output logic signed [DW-1:0] result_o
);
  localparam int SW   = PW + 1;
  localparam int HALF = 1 << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [SW-1:0] prod_x;
  logic signed [SW-1:0] bias;
  logic signed [SW-1:0] adj;
  logic signed [SW-1:0] quot;
  logic signed [SW-1:0] samp_x;
  logic signed [SW-1:0] sum;
  logic signed [DW-1:0] sat;
  logic signed [DW-1:0] result_d;

  always_comb begin
    prod_x = {prod_i[PW-1], prod_i};
    bias   = prod_i[PW-1] ? SW'(HALF - 1) : SW'(HALF);
    adj    = prod_x + bias;
    quot   = adj >>> FRAC;
    samp_x = {{(SW-DW){sample_i[DW-1]}}, sample_i};
    sum    = samp_x + quot;
    if (sum > MAXV)      sat = MAXV[DW-1:0];
    else if (sum < MINV) sat = MINV[DW-1:0];
    else                 sat = sum[DW-1:0];
    result_d = en_i ? sat : result_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_o <= '0;
    else        result_o <= result_d;
  end

  // R10: the result register is frozen when no sample advances
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(result_o));

  // R11: the gain never shrinks the magnitude
  p_gain_pos_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sample_i[DW-1]) |=> (result_o >= $past(sample_i)));
  p_gain_neg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sample_i[DW-1]) |=> (result_o <= $past(sample_i)));

  // R5: the top of the range saturates and never wraps
  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sample_i == MAXV[DW-1:0]) |=> (result_o == MAXV[DW-1:0]));
endmodule

// File: rtl/fgt_dual_trim.sv
`timescale 1ns/1ps
module fgt_dual_trim #(
  parameter int DW   = 14,
  parameter int CW   = 7,
  parameter int FRAC = fgt_pkg::FGT_FRAC_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic        [CW-1:0] code_a,
  input  logic        [CW-1:0] code_b,
  input  logic                 common_sel,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  import fgt_pkg::*;

  localparam int NCH = 2;
  localparam int PW  = DW + CW + 1;

  trim_mode_e            mode;
  logic [NCH*CW-1:0]     codes_raw;
  logic [NCH*CW-1:0]     codes_eff;
  logic [NCH*DW-1:0]     samp_in;
  logic [NCH*DW-1:0]     samp_out;
  logic                  v1_q, v1_d;
  logic                  v2_d;

  assign mode      = trim_mode_e'(common_sel);
  assign codes_raw = {code_b, code_a};
  assign samp_in   = {in_b, in_a};

  fgt_code_sel #(.NCH(NCH), .CW(CW)) u_code_sel (
    .mode_common_i (mode == MODE_COMMON),
    .codes_i       (codes_raw),
    .codes_o       (codes_eff)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic signed [DW-1:0] s1_sample;
    logic signed [PW-1:0] s1_prod;
    logic signed [DW-1:0] s2_result;

    fgt_product_stage #(.DW(DW), .CW(CW), .PW(PW)) u_prod (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (in_valid),
      .sample_i (samp_in[g*DW +: DW]),
      .code_i   (codes_eff[g*CW +: CW]),
      .sample_o (s1_sample),
      .prod_o   (s1_prod)
    );

    fgt_round_sat_stage #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_rsat (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (v1_q),
      .sample_i (s1_sample),
      .prod_i   (s1_prod),
      .result_o (s2_result)
    );

    assign samp_out[g*DW +: DW] = s2_result;
  end

  assign out_a = samp_out[DW-1:0];
  assign out_b = samp_out[2*DW-1:DW];

  always_comb begin
    v1_d = in_valid;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1_q      <= v1_d;
      out_valid <= v2_d;
    end
  end

  // R2: the valid strobe moves one stage per clock, no more and no less
  p_lat_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> v1_q);
  p_lat_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !v1_q);
  p_lat_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_valid);
  p_lat_out_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_valid);
endmodule

// File: tb/tb_fgt_dual_trim.sv
`timescale 1ns/1ps
module tb_fgt_dual_trim;
  localparam int DW = 14;
  localparam int CW = 7;
  localparam int MAXS = 8191;
  localparam int MINS = -8192;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic signed [DW-1:0] in_a, in_b;
  logic        [CW-1:0] code_a, code_b;
  logic                 common_sel;
  logic                 out_valid;
  logic signed [DW-1:0] out_a, out_b;

  int checks = 0;
  int errors = 0;

  int    q_v[$];
  int    q_ea[$];
  int    q_eb[$];
  int    q_ia[$];
  int    q_ib[$];
  string q_tag[$];
  int    held_a = 0;
  int    held_b = 0;

  fgt_dual_trim #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .code_a(code_a), .code_b(code_b),
    .common_sel(common_sel), .out_valid(out_valid),
    .out_a(out_a), .out_b(out_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int ref_gain(int x, int c);
    longint p, m, r, s;
    p = longint'(x) * longint'(c);
    m = (p < 0) ? -p : p;
    r = (m + 4096) / 8192;
    if (p < 0) r = -r;
    s = longint'(x) + r;
    if (s > MAXS) s = MAXS;
    if (s < MINS) s = MINS;
    return int'(s);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_ge(string tag, string what, int act, int bound, bit upper);
    checks++;
    if ((upper && act > bound) || (!upper && act < bound)) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected bound=%0d", tag, what, act, bound);
    end
  endtask

  task automatic compare_outputs();
    int v, ea, eb, ia, ib;
    string t;
    v = 0; ea = 0; eb = 0; ia = 0; ib = 0; t = "R2";
    if (q_v.size() == 2) begin
      v = q_v.pop_front();   ea = q_ea.pop_front(); eb = q_eb.pop_front();
      ia = q_ia.pop_front(); ib = q_ib.pop_front(); t = q_tag.pop_front();
    end
    check("R2", "out_valid", int'(out_valid), v);
    if (v != 0) begin
      check(t, "out_a", int'(out_a), ea);
      check(t, "out_b", int'(out_b), eb);
      check_ge("R11", "out_a vs in_a", int'(out_a), ia, ia < 0);
      check_ge("R11", "out_b vs in_b", int'(out_b), ib, ib < 0);
      held_a = ea;
      held_b = eb;
    end else begin
      check("R10", "out_a held", int'(out_a), held_a);
      check("R10", "out_b held", int'(out_b), held_b);
    end
  endtask

  task automatic drive(bit v, int a, int b, int ca, int cb, bit cm, string t);
    int eff_b;
    @(negedge clk);
    compare_outputs();
    in_valid   = v;
    in_a       = DW'(a);
    in_b       = DW'(b);
    code_a     = CW'(ca);
    code_b     = CW'(cb);
    common_sel = cm;
    eff_b = cm ? ca : cb;
    q_v.push_back(int'(v));
    q_ea.push_back(ref_gain(a, ca));
    q_eb.push_back(ref_gain(b, eff_b));
    q_ia.push_back(a);
    q_ib.push_back(b);
    q_tag.push_back(t);
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(0, 16383)) - 8192;
  endfunction

  function automatic int rnd_c();
    return int'($urandom_range(0, 127));
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    code_a = '0; code_b = '0; common_sel = 1'b0;
    repeat (2) @(negedge clk);
    in_valid = 1'b1; in_a = 14'sd1000; in_b = -14'sd1000; code_a = 7'd50;
    repeat (3) @(negedge clk);
    // R1: reset holds the outputs at zero even with in_valid high
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "out_a in reset", int'(out_a), 0);
    check("R1", "out_b in reset", int'(out_b), 0);
    rst_n = 1'b1; in_valid = 1'b0; code_a = '0;

    // R6: zero code is unity gain
    for (int i = 0; i < 40; i++) drive(1, rnd_s(), rnd_s(), 0, 0, 0, "R6");

    // R3: random codes, independent channels
    for (int i = 0; i < 300; i++) drive(1, rnd_s(), rnd_s(), rnd_c(), rnd_c(), 0, "R3");

    // R4: halfway products round away from zero
    drive(1,  4096,  2048, 1, 2, 0, "R4");
    drive(1, -4096, -2048, 1, 2, 0, "R4");
    drive(1,  4096, -4096, 3, 3, 0, "R4");
    drive(1, -4095,  4095, 1, 1, 0, "R4");
    drive(1,  8192 - 1, 1, 0, 127, 0, "R4");

    // R5: saturation at both limits
    drive(1,  MAXS,  MINS, 127, 127, 0, "R5");
    drive(1,  8100, -8100, 127, 127, 0, "R5");
    drive(1,  8064, -8064, 127, 127, 0, "R5");
    drive(1,  MAXS,  MINS,   1,   1, 0, "R5");

    // R8: fixed distinct codes per channel
    for (int i = 0; i < 40; i++) drive(1, rnd_s(), rnd_s(), 127, 5, 0, "R8");

    // R7: common mode, code_b must have no effect
    for (int i = 0; i < 200; i++) drive(1, rnd_s(), rnd_s(), rnd_c(), rnd_c(), 1, "R7");

    // R9: code and mode change on every cycle, samples back to back
    for (int i = 0; i < 400; i++)
      drive(($urandom_range(0, 3) != 0), rnd_s(), rnd_s(), rnd_c(), rnd_c(),
            bit'($urandom_range(0, 1)), "R9");

    // R10: sparse valid, outputs must hold across gaps
    for (int i = 0; i < 400; i++)
      drive(($urandom_range(0, 9) < 3), rnd_s(), rnd_s(), rnd_c(), rnd_c(),
            bit'($urandom_range(0, 1)), "R10");

    // drain
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule